// File: doc/BRIEF.md
# CAN Message Buffer and Event Interrupt Flags

This block gathers the interrupt sources of a CAN controller: the completion flags of the 32 message buffers in the upper bank (buffers 32 to 63), an error summary flag and a bus wake-up flag. Each buffer flag is set by a one-cycle pulse from the transfer engine. Software clears it by writing a 1 to it. A mask word gates each flag onto a single buffer interrupt request. The error summary flag follows a six-bit error input. The wake-up flag records a falling edge of the synchronized receive line while the controller is in stop mode. Each of these two flags has its own enable bit.

The block sits on a simple register bus with four words: mask, buffer flags, status and control. A write takes effect at the clock edge where `wr_en` is high. Every read returns the word chosen by `addr`, registered one cycle later, and has no side effect. All three requests are registered. They are computed from the next-state values, so a request changes at the same edge as the flag or mask that causes the change.

Top module: `can_irq_flags`

## Requirements
- R1: A synchronous active-high reset clears all mask bits, all flags and both enable bits, drives all three requests to 0 and drives `rd_data` to 0.
- R2: A write to address 0 loads the mask word. Bit k (LSB = 0) enables buffer 32+k, so the most significant bit is buffer 63. Writing 1 enables a buffer and writing 0 disables it. Reading address 0 returns the mask.
- R3: A pulse on `buf_set[k]` sets flag k. Writing address 1 clears each flag whose data bit is 1; data bits of 0 leave flags unchanged. When a set pulse and a clear hit the same flag in the same cycle, the flag ends up set. Reading address 1 returns the flags.
- R4: `buf_irq` is the OR over all buffers of flag AND mask. It changes at the same edge as the mask write, set pulse or clear that causes the change.
- R5: The error summary flag sets on every cycle in which any bit of `err_bits` is 1. The status word (address 2) shows `err_bits` in bits [15:10], the error summary flag in bit 1 and the wake-up flag in bit 0.
- R6: `err_irq` is 1 exactly when the error summary flag and the error enable bit (address 3, bit 0) are both 1.
- R7: Writing 1 to status bit 1 or status bit 0 clears the error summary flag or the wake-up flag. Writing 0 to those bits has no effect. A set in the same cycle wins over the clear.
- R8: `rx_line` (1 = recessive, 0 = dominant) passes through two synchronizer flops. The wake-up flag sets when the synchronized line goes from 1 to 0 while `stop_mode` is 1. The same falling edge has no effect while `stop_mode` is 0.
- R9: `wake_irq` is 1 exactly when the wake-up flag and the wake enable bit (address 3, bit 1) are both 1.
- R10: `rd_data` presents the addressed word as it stood before the clock edge, one cycle after `addr` is applied. Reading changes no flag, mask or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 mask, 1 flags, 2 status, 3 control |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| buf_set | input | 32 | Per-buffer set pulses, bit k = buffer 32+k |
| err_bits | input | 6 | Error condition bits |
| stop_mode | input | 1 | Controller is in stop mode |
| rx_line | input | 1 | Asynchronous CAN receive line |
| buf_irq | output | 1 | Buffer interrupt request |
| err_irq | output | 1 | Error interrupt request |
| wake_irq | output | 1 | Wake-up interrupt request |

## Verification
Some properties are checked on every cycle by the assertions:
- a set pulse always leaves its flag set on the next cycle;
- an all-zero mask never lets the buffer request through;
- any active error bit leaves the summary flag set;
- the error and wake requests never assert without both their flag and their enable bit;
- the wake-up flag only rises after a cycle spent in stop mode.

Other behaviour depends on ordering and history, so only the bench scenarios show it:
- set versus clear in the same cycle;
- a mask write switching the request on or off at the exact edge;
- the synchronizer delay before a wake edge registers;
- a falling edge outside stop mode being ignored;
- reads leaving the state untouched.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_MASK = 2'd0,
    REG_FLAG = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;

  localparam int STAT_WAKE_BIT  = 0;
  localparam int STAT_ERR_BIT   = 1;
  localparam int ERR_FIELD_LO   = 10;
  localparam int CTRL_EMASK_BIT = 0;
  localparam int CTRL_WMASK_BIT = 1;
endpackage

// File: rtl/cirq_buf_bank.sv
module cirq_buf_bank #(
  parameter int NUM_BUF = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mask_we,
  input  logic               flag_we,
  input  logic [NUM_BUF-1:0] wdata,
  input  logic [NUM_BUF-1:0] buf_set,
  output logic [NUM_BUF-1:0] mask_q,
  output logic [NUM_BUF-1:0] flag_q,
  output logic               irq
);
  logic [NUM_BUF-1:0] mask_d;
  logic [NUM_BUF-1:0] flag_d;

  assign mask_d = mask_we ? wdata : mask_q;

  // per-buffer flag: hardware set dominates a software clear
  for (genvar k = 0; k < NUM_BUF; k++) begin : g_flag
    assign flag_d[k] = buf_set[k] | (flag_q[k] & ~(flag_we & wdata[k]));

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
      buf_set[k] |=> flag_q[k]); // R3
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      flag_q <= '0;
      irq    <= 1'b0;
    end else begin
      mask_q <= mask_d;
      flag_q <= flag_d;
      irq    <= |(mask_d & flag_d);
    end
  end

  AST_NO_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |-> !irq); // R4
endmodule

// File: rtl/cirq_event_flags.sv
module cirq_event_flags #(
  parameter int ERR_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic             clr_err,
  input  logic             clr_wake,
  input  logic             emask_wd,
  input  logic             wmask_wd,
  input  logic [ERR_W-1:0] err_bits,
  input  logic             stop_mode,
  input  logic             rx_line,
  output logic             err_flag,
  output logic             wake_flag,
  output logic             err_mask,
  output logic             wake_mask,
  output logic             err_irq,
  output logic             wake_irq
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rx_cur;
  logic                   wake_edge;
  logic                   err_d, wake_d, emask_d, wmask_d;

  assign rx_cur    = sync_q[SYNC_STAGES-1];
  assign wake_edge = prev_q & ~rx_cur & stop_mode;

  assign err_d   = (|err_bits) | (err_flag & ~clr_err);
  assign wake_d  = wake_edge | (wake_flag & ~clr_wake);
  assign emask_d = ctrl_we ? emask_wd : err_mask;
  assign wmask_d = ctrl_we ? wmask_wd : wake_mask;

  // receive line synchronizer, idles recessive
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[s] <= 1'b1;
      else if (s == 0) sync_q[s] <= rx_line;
      else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= 1'b1;
      err_flag  <= 1'b0;
      wake_flag <= 1'b0;
      err_mask  <= 1'b0;
      wake_mask <= 1'b0;
      err_irq   <= 1'b0;
      wake_irq  <= 1'b0;
    end else begin
      prev_q    <= rx_cur;
      err_flag  <= err_d;
      wake_flag <= wake_d;
      err_mask  <= emask_d;
      wake_mask <= wmask_d;
      err_irq   <= err_d & emask_d;
      wake_irq  <= wake_d & wmask_d;
    end
  end

  AST_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
    (|err_bits) |=> err_flag); // R5
  AST_ERR_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> (err_flag && err_mask)); // R6
  AST_WAKE_IN_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_flag) |-> $past(stop_mode)); // R8
  AST_WAKE_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    wake_irq |-> (wake_flag && wake_mask)); // R9
endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
  import can_irq_pkg::*;
#(
  parameter int NUM_BUF     = 32,
  parameter int DATA_W      = 32,
  parameter int ERR_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [NUM_BUF-1:0]    buf_set,
  input  logic [ERR_W-1:0]      err_bits,
  input  logic                  stop_mode,
  input  logic                  rx_line,
  output logic                  buf_irq,
  output logic                  err_irq,
  output logic                  wake_irq
);
  localparam int FIELD_HI = ERR_FIELD_LO + ERR_W;

  logic [NUM_BUF-1:0] mask_q, flag_q;
  logic               err_flag, wake_flag, err_mask, wake_mask;
  logic               mask_we, flag_we, stat_we, ctrl_we;
  logic [DATA_W-1:0]  stat_word, ctrl_word, rd_mux;

  assign mask_we = wr_en && (addr == REG_MASK);
  assign flag_we = wr_en && (addr == REG_FLAG);
  assign stat_we = wr_en && (addr == REG_STAT);
  assign ctrl_we = wr_en && (addr == REG_CTRL);

  cirq_buf_bank #(.NUM_BUF(NUM_BUF)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .mask_we (mask_we),
    .flag_we (flag_we),
    .wdata   (wr_data[NUM_BUF-1:0]),
    .buf_set (buf_set),
    .mask_q  (mask_q),
    .flag_q  (flag_q),
    .irq     (buf_irq)
  );

  cirq_event_flags #(.ERR_W(ERR_W), .SYNC_STAGES(SYNC_STAGES)) u_evt (
    .clk       (clk),
    .rst       (rst),
    .ctrl_we   (ctrl_we),
    .clr_err   (stat_we && wr_data[STAT_ERR_BIT]),
    .clr_wake  (stat_we && wr_data[STAT_WAKE_BIT]),
    .emask_wd  (wr_data[CTRL_EMASK_BIT]),
    .wmask_wd  (wr_data[CTRL_WMASK_BIT]),
    .err_bits  (err_bits),
    .stop_mode (stop_mode),
    .rx_line   (rx_line),
    .err_flag  (err_flag),
    .wake_flag (wake_flag),
    .err_mask  (err_mask),
    .wake_mask (wake_mask),
    .err_irq   (err_irq),
    .wake_irq  (wake_irq)
  );

  always_comb begin
    stat_word = '0;
    stat_word[FIELD_HI-1:ERR_FIELD_LO] = err_bits;
    stat_word[STAT_ERR_BIT]  = err_flag;
    stat_word[STAT_WAKE_BIT] = wake_flag;
    ctrl_word = '0;
    ctrl_word[CTRL_EMASK_BIT] = err_mask;
    ctrl_word[CTRL_WMASK_BIT] = wake_mask;
    rd_mux = '0;
    case (addr)
      REG_MASK: rd_mux[NUM_BUF-1:0] = mask_q;
      REG_FLAG: rd_mux[NUM_BUF-1:0] = flag_q;
      REG_STAT: rd_mux = stat_word;
      default:  rd_mux = ctrl_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  AST_READ_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && buf_set == '0) |=> $stable(flag_q)); // R10
endmodule

// File: tb/can_irq_flags_test.sv
module can_irq_flags_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] buf_set = '0;
  logic [5:0]  err_bits = '0;
  logic        stop_mode = 1'b0;
  logic        rx_line = 1'b1;
  logic        buf_irq, err_irq, wake_irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  can_irq_flags uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .buf_set(buf_set), .err_bits(err_bits),
    .stop_mode(stop_mode), .rx_line(rx_line), .buf_irq(buf_irq),
    .err_irq(err_irq), .wake_irq(wake_irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit        armed = 0;
  bit [31:0] m_mask, m_flag, m_rd;
  bit        m_err, m_wake, m_emask, m_wmask;
  bit        m_bi, m_ei, m_wi;
  bit        rx_hist[$];

  always @(posedge clk) begin
    if (rst) begin
      armed = 1;
      m_mask = 0; m_flag = 0; m_rd = 0;
      m_err = 0; m_wake = 0; m_emask = 0; m_wmask = 0;
      m_bi = 0; m_ei = 0; m_wi = 0;
      rx_hist = '{1'b1, 1'b1, 1'b1};
    end else begin
      bit fall;
      case (addr)
        2'd0: m_rd = m_mask;
        2'd1: m_rd = m_flag;
        2'd2: m_rd = {16'b0, err_bits, 8'b0, m_err, m_wake};
        default: m_rd = {30'b0, m_wmask, m_emask};
      endcase
      // rx_hist[0] newest stage, [1] synchronized, [2] previous synchronized
      fall = rx_hist[2] && !rx_hist[1] && stop_mode;
      if (wr_en && addr == 2'd0) m_mask = wr_data;
      if (wr_en && addr == 2'd1) m_flag = m_flag & ~wr_data;
      m_flag = m_flag | buf_set;
      if (wr_en && addr == 2'd2 && wr_data[1]) m_err = 0;
      if (wr_en && addr == 2'd2 && wr_data[0]) m_wake = 0;
      if (err_bits != 0) m_err = 1;
      if (fall) m_wake = 1;
      if (wr_en && addr == 2'd3) begin m_emask = wr_data[0]; m_wmask = wr_data[1]; end
      void'(rx_hist.pop_back());
      rx_hist.push_front(rx_line);
      m_bi = (m_mask & m_flag) != 0;
      m_ei = m_err && m_emask;
      m_wi = m_wake && m_wmask;
    end
  end

  logic [1:0] last_addr = 2'd0;
  always @(posedge clk) last_addr <= addr;

  always @(negedge clk) begin
    if (armed) begin
      check("R4 buf_irq", {31'b0, buf_irq}, {31'b0, m_bi});
      check("R6 err_irq", {31'b0, err_irq}, {31'b0, m_ei});
      check("R9 wake_irq", {31'b0, wake_irq}, {31'b0, m_wi});
      case (last_addr)
        2'd0: check("R2 read mask", rd_data, m_rd);
        2'd1: check("R3 read flags", rd_data, m_rd);
        2'd2: check("R7 read status", rd_data, m_rd);
        default: check("R10 read control", rd_data, m_rd);
      endcase
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic bus_wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic bus_rd(logic [1:0] a, logic [31:0] exp, string tag);
    addr = a;
    tick();
    check(tag, rd_data, exp);
  endtask

  task automatic pulse(logic [31:0] v);
    buf_set = v;
    tick();
    buf_set = '0;
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    check("R1 reset buf_irq", {31'b0, buf_irq}, 32'd0);
    check("R1 reset rd_data", rd_data, 32'd0);
    bus_rd(2'd1, 32'd0, "R1 reset flags");

    // mask bit order: MSB is buffer 63, LSB buffer 32
    bus_wr(2'd0, 32'h8000_0001);
    bus_rd(2'd0, 32'h8000_0001, "R2 mask readback");

    pulse(32'h0000_0001);
    check("R4 flag and mask", {31'b0, buf_irq}, 32'd1);
    pulse(32'h0000_0100);
    bus_wr(2'd1, 32'h0000_0001);
    check("R4 cleared masked flag", {31'b0, buf_irq}, 32'd0);
    bus_rd(2'd1, 32'h0000_0100, "R3 only written bit cleared");
    bus_wr(2'd0, 32'h0000_0100);
    check("R4 mask write raises request", {31'b0, buf_irq}, 32'd1);
    bus_wr(2'd0, 32'h0);
    check("R4 mask write drops request", {31'b0, buf_irq}, 32'd0);
    bus_wr(2'd1, 32'h0);
    bus_rd(2'd1, 32'h0000_0100, "R3 zero write keeps flags");
    // set and clear collide on buffer 40
    wr_en = 1'b1; addr = 2'd1; wr_data = 32'h0000_0100; buf_set = 32'h0000_0100;
    tick();
    wr_en = 1'b0; wr_data = '0; buf_set = '0;
    bus_rd(2'd1, 32'h0000_0100, "R3 set wins over clear");

    // mixed patterns
    lfsr = 32'hACE1_1357;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      buf_set = lfsr & 32'h0101_0811;
      wr_en = lfsr[5]; addr = {1'b0, lfsr[9]}; wr_data = lfsr ^ 32'h5A5A_0F0F;
      tick();
    end
    buf_set = '0; wr_en = 1'b0;
    bus_wr(2'd1, 32'hFFFF_FFFF);
    bus_rd(2'd1, 32'h0, "R3 clear all");

    // error summary
    err_bits = 6'b000100;
    tick();
    err_bits = 6'b100000;
    addr = 2'd2;
    tick();
    check("R5 status shows error field and flag", rd_data, 32'h0000_8002);
    err_bits = '0;
    check("R6 no request while disabled", {31'b0, err_irq}, 32'd0);
    bus_wr(2'd3, 32'h1);
    check("R6 enable raises request", {31'b0, err_irq}, 32'd1);
    bus_wr(2'd2, 32'h0);
    check("R7 zero write keeps error flag", {31'b0, err_irq}, 32'd1);
    err_bits = 6'b000001;
    bus_wr(2'd2, 32'h2);
    err_bits = '0;
    check("R7 set wins over clear", {31'b0, err_irq}, 32'd1);
    bus_wr(2'd2, 32'h2);
    check("R7 clear error flag", {31'b0, err_irq}, 32'd0);

    // wake edge outside stop mode is ignored
    bus_wr(2'd3, 32'h2);
    stop_mode = 1'b0;
    rx_line = 1'b0;
    repeat (5) tick();
    bus_rd(2'd2, 32'h0, "R8 no wake outside stop");
    rx_line = 1'b1;
    repeat (4) tick();
    stop_mode = 1'b1;
    rx_line = 1'b0;
    tick();
    tick();
    check("R8 synchronizer delay", {31'b0, wake_irq}, 32'd0);
    tick();
    check("R9 wake request", {31'b0, wake_irq}, 32'd1);
    bus_rd(2'd2, 32'h1, "R8 wake flag set");
    bus_rd(2'd2, 32'h1, "R10 read has no side effect");
    stop_mode = 1'b0;
    bus_wr(2'd2, 32'h1);
    check("R7 clear wake flag", {31'b0, wake_irq}, 32'd0);
    bus_wr(2'd3, 32'h0);
    bus_rd(2'd3, 32'h0, "R10 control readback");

    repeat (3) tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule